// File: doc/BRIEF.md
# Video Component Separating Word Packer

This block takes a stream of 8-bit interleaved 4:2:2 component video samples, one per clock while a valid flag is high. It sorts them into three streams: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). Each stream is gathered into 64-bit words of eight samples. When a word is full it is presented to that component's FIFO write port together with a one-cycle write strobe. Partial words are never written.

A line-start pulse or a synchronous reset clears the sample-phase counter and all three lane counters, and any partial words are discarded. The byte order inside a word is set by a mode input. In little-endian mode the earliest sample of the word goes to the low byte. In big-endian mode it goes to the high byte. The mode is captured only at reset or at a line start and holds for the rest of the line.

Top module: `vid_comp_packer`

## Requirements
- R1: After a line start, valid samples are assigned to components in the repeating order Cb, Y, Cr, Y, starting with Cb. Each component word holds only consecutive samples of that component.
- R2: With continuous input, a Y word completes every 16 valid samples and a Cb or Cr word completes every 32 valid samples. At most one of the three write strobes is high in any cycle.
- R3: In little-endian mode (big_endian = 0 at capture), the first sample of a word is in bits [7:0] and sample k of the word is in bits [8k+7:8k].
- R4: In big-endian mode (big_endian = 1 at capture), the first sample of a word is in bits [63:56] and sample k of the word is in bits [63-8k:56-8k].
- R5: A write strobe is high for exactly one cycle. It appears in the cycle right after the clock edge that captures the word's eighth sample, and the completed word is on the data output during that cycle.
- R6: A cycle with sample_valid low has no effect on the phase, the lane counters or the words.
- R7: line_start clears the phase and lane counters and drops partial words. A sample that is valid in the same cycle as line_start is ignored. No write strobe follows a line_start cycle.
- R8: A synchronous reset sets all write strobes and data outputs to zero and drops partial words.
- R9: big_endian is captured only during reset or line_start. A change in the middle of a line does not affect words written in that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | One-cycle pulse that restarts the phase and lane counters |
| sample_valid | input | 1 | High when sample carries an active-video sample |
| sample | input | 8 | Interleaved component sample |
| big_endian | input | 1 | Byte order, captured at reset or line start (1 = first sample in the high byte) |
| y_data | output | 64 | Completed luma word |
| y_wr | output | 1 | Luma FIFO write strobe |
| cb_data | output | 64 | Completed Cb word |
| cb_wr | output | 1 | Cb FIFO write strobe |
| cr_data | output | 64 | Completed Cr word |
| cr_wr | output | 1 | Cr FIFO write strobe |

## Verification
Each write strobe and its word is due one clock after the edge that captures the eighth sample of that component, and nothing is due at any other time. The bench drives inputs 1 ns after a rising edge. The latency test reads the strobe 1 ns after the capturing edge and again one cycle later, to confirm the single-cycle pulse. A monitor records every strobed word at the falling edge. Each line is given three idle cycles to drain before the recorded words and counts are compared with values computed from the sample index and the captured byte order.

// File: rtl/vid_comp_packer.sv
module vid_comp_packer #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        line_start,
  input  logic                        sample_valid,
  input  logic [SAMPLE_W-1:0]         sample,
  input  logic                        big_endian,
  output logic [SAMPLE_W*LANES-1:0]   y_data,
  output logic                        y_wr,
  output logic [SAMPLE_W*LANES-1:0]   cb_data,
  output logic                        cb_wr,
  output logic [SAMPLE_W*LANES-1:0]   cr_data,
  output logic                        cr_wr
);
  localparam int WORD_W = SAMPLE_W * LANES;
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int NCOMP  = 3;

  logic [1:0]       phase;
  logic             be_q;
  logic [NCOMP-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst || line_start) begin
      phase <= '0;
      be_q  <= big_endian;
    end else if (sample_valid) begin
      phase <= phase + 2'd1;
    end
  end

  always_comb begin
    hit = '0;
    if (sample_valid && !line_start) begin
      if (phase[0])      hit[0] = 1'b1;
      else if (phase[1]) hit[2] = 1'b1;
      else               hit[1] = 1'b1;
    end
  end

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [LW-1:0]     lane;
    logic [LW-1:0]     pos;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word;
    logic              wr;

    assign pos = be_q ? LW'(LANES - 1) - lane : lane;

    always_comb begin
      merged = acc;
      merged[pos*SAMPLE_W +: SAMPLE_W] = sample;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lane <= '0;
        acc  <= '0;
        word <= '0;
        wr   <= 1'b0;
      end else if (line_start) begin
        lane <= '0;
        acc  <= '0;
        wr   <= 1'b0;
      end else begin
        wr <= 1'b0;
        if (hit[c]) begin
          if (lane == LW'(LANES - 1)) begin
            lane <= '0;
            acc  <= '0;
            word <= merged;
            wr   <= 1'b1;
          end else begin
            lane <= lane + 1'b1;
            acc  <= merged;
          end
        end
      end
    end
  end

  assign y_data  = g_comp[0].word;
  assign y_wr    = g_comp[0].wr;
  assign cb_data = g_comp[1].word;
  assign cb_wr   = g_comp[1].wr;
  assign cr_data = g_comp[2].word;
  assign cr_wr   = g_comp[2].wr;
endmodule

module vid_comp_packer_chk #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      line_start,
  input logic                      sample_valid,
  input logic [SAMPLE_W-1:0]       sample,
  input logic [SAMPLE_W*LANES-1:0] y_data,
  input logic                      y_wr,
  input logic                      cb_wr,
  input logic                      cr_wr
);
  localparam int WORD_W = SAMPLE_W * LANES;

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({y_wr, cb_wr, cr_wr}));

  assert_y_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    y_wr |=> !y_wr);
  assert_cb_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cb_wr |=> !cb_wr);
  assert_cr_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cr_wr |=> !cr_wr);

  assert_wr_needs_sample_R6: assert property (@(posedge clk) disable iff (rst)
    (y_wr || cb_wr || cr_wr) |-> $past(sample_valid && !line_start));

  assert_no_wr_after_line_R7: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !(y_wr || cb_wr || cr_wr));

  assert_y_last_byte_R4: assert property (@(posedge clk) disable iff (rst)
    y_wr |-> (y_data[SAMPLE_W-1:0] == $past(sample) ||
              y_data[WORD_W-1:WORD_W-SAMPLE_W] == $past(sample)));
endmodule

bind vid_comp_packer vid_comp_packer_chk #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .line_start(line_start), .sample_valid(sample_valid),
  .sample(sample), .y_data(y_data), .y_wr(y_wr), .cb_wr(cb_wr), .cr_wr(cr_wr)
);

// File: tb/vid_comp_packer_tb.sv
`timescale 1ns/1ps
module vid_comp_packer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_start = 1'b0;
  logic        sample_valid = 1'b0;
  logic [7:0]  sample = 8'h00;
  logic        big_endian = 1'b0;
  logic [63:0] y_data, cb_data, cr_data;
  logic        y_wr, cb_wr, cr_wr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] got [3][8];
  int          ngot [3];

  always #2.5 clk = ~clk;

  vid_comp_packer u_dut (
    .clk(clk), .rst(rst), .line_start(line_start), .sample_valid(sample_valid),
    .sample(sample), .big_endian(big_endian),
    .y_data(y_data), .y_wr(y_wr), .cb_data(cb_data), .cb_wr(cb_wr),
    .cr_data(cr_data), .cr_wr(cr_wr)
  );

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (y_wr  && ngot[0] < 8) begin got[0][ngot[0]] = y_data;  ngot[0]++; end
        if (cb_wr && ngot[1] < 8) begin got[1][ngot[1]] = cb_data; ngot[1]++; end
        if (cr_wr && ngot[2] < 8) begin got[2][ngot[2]] = cr_data; ngot[2]++; end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_word(int comp, int w, logic [7:0] seed, bit be);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) begin
      int j = 8 * w + k;
      int idx = (comp == 0) ? 2 * j + 1 : (comp == 1) ? 4 * j : 4 * j + 2;
      logic [7:0] v = seed + 8'(idx * 3 + 1);
      if (be) r[(7 - k) * 8 +: 8] = v;
      else    r[k * 8 +: 8] = v;
    end
    return r;
  endfunction

  task automatic clear_log();
    for (int c = 0; c < 3; c++) ngot[c] = 0;
  endtask

  task automatic feed(int n, logic [7:0] seed, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sample_valid = 1'b1;
      sample = seed + 8'(i * 3 + 1);
      if (gaps) begin
        @(posedge clk); #1;
        sample_valid = 1'b0;
        sample = 8'hA5;
      end
    end
    @(posedge clk); #1;
    sample_valid = 1'b0;
  endtask

  task automatic start_line(bit be, bit junk);
    @(posedge clk); #1;
    big_endian = be;
    line_start = 1'b1;
    sample_valid = junk;
    sample = 8'hEE;
    @(posedge clk); #1;
    line_start = 1'b0;
    sample_valid = 1'b0;
    clear_log();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic check_line(string req, logic [7:0] seed, bit be, int ny, int nc);
    chk(ngot[0] == ny, {req, " R2 Y word count"}, 64'(ngot[0]), 64'(ny));
    chk(ngot[1] == nc, {req, " R2 Cb word count"}, 64'(ngot[1]), 64'(nc));
    chk(ngot[2] == nc, {req, " R2 Cr word count"}, 64'(ngot[2]), 64'(nc));
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < ngot[c] && w < 8; w++)
        chk(got[c][w] == exp_word(c, w, seed, be), {req, " R1 word data"},
            got[c][w], exp_word(c, w, seed, be));
  endtask

  // {big_endian, idle gaps, seed}
  localparam logic [9:0] VEC [5] = '{
    {1'b0, 1'b0, 8'h00},
    {1'b1, 1'b0, 8'h10},
    {1'b0, 1'b1, 8'h40},
    {1'b1, 1'b1, 8'h7F},
    {1'b0, 1'b0, 8'hF0}
  };

  initial begin
    clear_log();
    idle(3);
    chk(!y_wr && !cb_wr && !cr_wr, "R8 reset strobes", 64'({y_wr, cb_wr, cr_wr}), 64'd0);
    chk(y_data == 0 && cb_data == 0 && cr_data == 0, "R8 reset data",
        y_data | cb_data | cr_data, 64'd0);
    rst = 1'b0;

    // table walk: R1 order, R2 rate, R3/R4 byte order, R6 idle gaps
    foreach (VEC[v]) begin
      start_line(VEC[v][9], 1'b0);
      feed(64, VEC[v][7:0], VEC[v][8]);
      idle(3);
      check_line(VEC[v][9] ? "R4 vec" : (VEC[v][8] ? "R6 R3 vec" : "R3 vec"),
                 VEC[v][7:0], VEC[v][9], 4, 2);
    end

    // R5: strobe latency and width
    start_line(1'b0, 1'b0);
    feed(15, 8'h20, 1'b0);
    chk(!y_wr, "R5 no early strobe", 64'(y_wr), 64'd0);
    feed(1, 8'h20 + 8'(15 * 3), 1'b0);
    chk(y_wr, "R5 strobe after 16th sample", 64'(y_wr), 64'd1);
    idle(1);
    chk(!y_wr, "R5 single-cycle strobe", 64'(y_wr), 64'd0);

    // R7: partial words dropped, sample in line_start cycle ignored
    start_line(1'b0, 1'b0);
    feed(7, 8'h33, 1'b0);
    start_line(1'b1, 1'b1);
    idle(2);
    chk(ngot[0] == 0 && ngot[1] == 0 && ngot[2] == 0, "R7 no write after line start",
        64'(ngot[0] + ngot[1] + ngot[2]), 64'd0);
    feed(32, 8'h55, 1'b0);
    idle(3);
    check_line("R7 restart", 8'h55, 1'b1, 2, 1);

    // R8: reset mid-word drops partial words
    start_line(1'b0, 1'b0);
    feed(9, 8'h66, 1'b0);
    @(posedge clk); #1; rst = 1'b1;
    @(posedge clk); #1;
    chk(!y_wr && y_data == 0, "R8 reset clears output", y_data, 64'd0);
    rst = 1'b0;
    clear_log();
    feed(32, 8'h08, 1'b0);
    idle(3);
    check_line("R8 after reset", 8'h08, 1'b0, 2, 1);

    // R9: mode change mid-line has no effect
    start_line(1'b0, 1'b0);
    feed(16, 8'h90, 1'b0);
    big_endian = 1'b1;
    for (int i = 16; i < 32; i++) begin
      @(posedge clk); #1;
      sample_valid = 1'b1;
      sample = 8'h90 + 8'(i * 3 + 1);
    end
    @(posedge clk); #1; sample_valid = 1'b0;
    idle(3);
    check_line("R9 mode held", 8'h90, 1'b0, 2, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule